// File: doc/BRIEF.md
# Serial-Programmed Four-Channel Switch Control Core

This block is the digital core of a four-channel low-side switch driver. A host writes channel enables over a four-wire serial port (select, clock, data in, data out) and reads per-channel fault flags back over the same port. Each channel's enable is a stored bit set by the serial port, ORed with a dedicated parallel input. The parallel input lets an external PWM source drive a channel directly, which the serial port alone could not do at a useful rate.

All four port pins pass through synchronisers into the system clock domain, so the serial clock must run well below the system clock. Falling select starts a frame and loads the fault flags into the shift register. Data bits enter on rising serial clock edges and the register shifts on falling edges, most significant bit first. Rising select copies the low nibble of the register into the enable latches. A host can send two bytes in one frame to verify its command: the first byte it sent comes back on the data output during the second byte.

Top module: `qsw_spi_ctrl`

## Requirements
- R1: After reset all channel enables are off, ch_on_o is 0 while par_i is 0, so_o is 0, and the shift register is cleared.
- R2: When csb_i falls, the shift register loads a byte with the four fault_i flags in bits 3..0 and zeros in bits 7..4. During an 8-bit frame so_o presents that byte MSB first.
- R3: si_i is captured on rising sclk_i edges. The register shifts and so_o changes only on falling sclk_i edges, never on a rising edge.
- R4: When csb_i rises, register bits 3..0 (the last four bits received, bit 0 the last) become the channel enables, with bit n enabling channel n. Bits 7..4 have no effect on the outputs.
- R5: Each ch_on_o bit is the OR of its enable latch and its par_i bit.
- R6: In a 16-bit frame, so_o carries the fault byte and then the first received byte. The last four bits received set the enables.
- R7: A frame with no sclk_i edges still updates the enables on the rise of csb_i, taking them from the fault flags loaded at its start.
- R8: While csb_i is high, sclk_i and si_i activity changes neither the outputs nor the data returned in the next frame.
- R9: While csb_i is high, so_o is 0 and so_oe_o is 0 (SO_IDLE_HIZ=1). While csb_i is low, so_oe_o is 1.
- R10: The enable latches change only on the rise of csb_i. During a frame, ch_on_o keeps its value from before the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csb_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o (low means high impedance) |
| fault_i | input | NUM_CH | Per-channel fault flags from the detectors |
| par_i | input | NUM_CH | Direct parallel enables |
| ch_on_o | output | NUM_CH | Channel drive enables |

## Verification
A table of frames runs 8-bit and 16-bit transfers. Each transfer uses a different command, fault pattern and parallel pattern. This separates a read-back of the fault byte from an echo of the command, and the low nibble from the ignored upper nibble. Mixing parallel inputs that are set with latches that are clear, and the reverse, tells the OR apart from a pass-through of either source. Directed cases follow. One frame has no clock edges. One toggles the serial clock while select is high. One watches SO across a single clock pulse to tell a shift on the rising edge from a shift on the falling edge.

// File: rtl/qsw_pkg.sv
package qsw_pkg;
  // Positions of the port pins inside the synchroniser vector
  localparam int unsigned SYNC_W  = 3;
  localparam int unsigned CSB_IX  = 0;
  localparam int unsigned SCLK_IX = 1;
  localparam int unsigned SI_IX   = 2;
  // Idle pin levels: select high, clock low, data low
  localparam logic [SYNC_W-1:0] PIN_IDLE = 3'b001;
endpackage

// File: rtl/qsw_edge_sync.sv
module qsw_edge_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [STAGES-1:0][W-1:0] stg_q, stg_d;
  logic [W-1:0] prev_q;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      stg_q  <= stg_d;
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/qsw_shifter.sv
module qsw_shifter #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act_i,
  input  logic              cs_fall_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              si_i,
  input  logic [NUM_CH-1:0] fault_i,
  output logic [WORD_W-1:0] sr_o
);
  localparam int unsigned PAD_W = WORD_W - NUM_CH;

  logic [WORD_W-1:0] sr_q, sr_d;
  logic              hold_q, hold_d;
  logic              sr_en, hold_en;

  // Clock enables
  assign sr_en   = cs_fall_i | (cs_act_i & sclk_fall_i);
  assign hold_en = cs_act_i & ~cs_fall_i & sclk_rise_i;

  always_comb begin
    sr_d   = sr_q;
    hold_d = hold_q;
    if (cs_fall_i) begin
      sr_d = {{PAD_W{1'b0}}, fault_i};
    end else if (sr_en) begin
      sr_d = {sr_q[WORD_W-2:0], hold_q};
    end
    if (hold_en) begin
      hold_d = si_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      hold_q <= 1'b0;
    end else begin
      if (sr_en)   sr_q   <= sr_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/qsw_out_latch.sv
module qsw_out_latch #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [NUM_CH-1:0] d_i,
  input  logic [NUM_CH-1:0] par_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] ch_on_o
);
  logic [NUM_CH-1:0] en_q, en_d;

  always_comb begin
    en_d = load_i ? d_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (load_i) en_q <= en_d;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_on_o[c] = en_q[c] | par_i[c];
  end

  assign en_o = en_q;
endmodule

// File: rtl/qsw_spi_ctrl.sv
module qsw_spi_ctrl
  import qsw_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned WORD_W = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit SO_IDLE_HIZ = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csb_i,
  input  logic              sclk_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic [NUM_CH-1:0] fault_i,
  input  logic [NUM_CH-1:0] par_i,
  output logic [NUM_CH-1:0] ch_on_o
);
  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic [SYNC_W-1:0] pin_lvl, pin_rise, pin_fall;

  qsw_edge_sync #(
    .W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk(clk), .rst_n(rst_int_n),
    .d_i({si_i, sclk_i, csb_i}),
    .lvl_o(pin_lvl), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  logic cs_act, cs_fall, cs_rise;
  assign cs_act  = ~pin_lvl[CSB_IX];
  assign cs_fall = pin_fall[CSB_IX];
  assign cs_rise = pin_rise[CSB_IX];

  logic [WORD_W-1:0] sr;
  logic [NUM_CH-1:0] en_q;

  qsw_shifter #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_shift (
    .clk(clk), .rst_n(rst_int_n),
    .cs_act_i(cs_act), .cs_fall_i(cs_fall),
    .sclk_rise_i(pin_rise[SCLK_IX]), .sclk_fall_i(pin_fall[SCLK_IX]),
    .si_i(pin_lvl[SI_IX]), .fault_i(fault_i), .sr_o(sr)
  );

  qsw_out_latch #(.NUM_CH(NUM_CH)) u_latch (
    .clk(clk), .rst_n(rst_int_n),
    .load_i(cs_rise), .d_i(sr[NUM_CH-1:0]), .par_i(par_i),
    .en_o(en_q), .ch_on_o(ch_on_o)
  );

  assign so_o    = cs_act & sr[WORD_W-1];
  assign so_oe_o = cs_act | ~SO_IDLE_HIZ;
endmodule

// File: rtl/qsw_spi_ctrl_chk.sv
module qsw_spi_ctrl_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned WORD_W = 8,
  parameter bit SO_IDLE_HIZ = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              cs_fall,
  input logic              cs_rise,
  input logic              sclk_fall,
  input logic [WORD_W-1:0] sr,
  input logic [NUM_CH-1:0] en_q,
  input logic [NUM_CH-1:0] fault_i,
  input logic [NUM_CH-1:0] par_i,
  input logic [NUM_CH-1:0] ch_on_o,
  input logic              so_o,
  input logic              so_oe_o
);
  // R2
  fault_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (sr == {{(WORD_W-NUM_CH){1'b0}}, $past(fault_i)}));

  // R4
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (en_q == $past(sr[NUM_CH-1:0])));

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(en_q));

  // R3
  shift_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !cs_fall && !sclk_fall) |=> $stable(sr));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> $stable(sr));

  // R5
  par_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((par_i & ~ch_on_o) == '0));

  // R9
  so_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> (!so_o && (so_oe_o == !SO_IDLE_HIZ)));
endmodule

bind qsw_spi_ctrl qsw_spi_ctrl_chk #(
  .NUM_CH(NUM_CH), .WORD_W(WORD_W), .SO_IDLE_HIZ(SO_IDLE_HIZ)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .cs_act(cs_act), .cs_fall(cs_fall),
  .cs_rise(cs_rise), .sclk_fall(pin_fall[qsw_pkg::SCLK_IX]), .sr(sr),
  .en_q(en_q), .fault_i(fault_i), .par_i(par_i), .ch_on_o(ch_on_o),
  .so_o(so_o), .so_oe_o(so_oe_o)
);

// File: tb/sim_qsw_spi_ctrl.sv
module sim_qsw_spi_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csb = 1'b1, sclk = 1'b0, si = 1'b0;
  logic       so, so_oe;
  logic [3:0] fault = '0, par = '0, ch_on;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  qsw_spi_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .csb_i(csb), .sclk_i(sclk), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .fault_i(fault), .par_i(par), .ch_on_o(ch_on)
  );

  typedef struct packed {
    logic [4:0]  nbits;
    logic [15:0] tx;
    logic [3:0]  flt;
    logic [3:0]  pin;
    logic [15:0] exp_so;
    logic [3:0]  exp_on;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{5'd8,  16'h00A5, 4'h0, 4'h0, 16'h0000, 4'h5},
    '{5'd8,  16'h003C, 4'hA, 4'h0, 16'h000A, 4'hC},
    '{5'd8,  16'h00F0, 4'h5, 4'h3, 16'h0005, 4'h3},
    '{5'd8,  16'h0009, 4'hF, 4'h6, 16'h000F, 4'hF},
    '{5'd16, 16'h5AC3, 4'h3, 4'h0, 16'h035A, 4'h3},
    '{5'd16, 16'h8106, 4'h8, 4'h0, 16'h0881, 4'h6}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input int nbits, input logic [15:0] tx,
                           output logic [15:0] rx, output logic [3:0] mid_on);
    rx = '0;
    csb = 1'b0;
    wait_clk(5);
    for (int i = 0; i < nbits; i++) begin
      si = tx[nbits-1-i];
      wait_clk(4);
      rx[nbits-1-i] = so;
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(5);
    mid_on = ch_on;
    csb = 1'b1;
    wait_clk(6);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] rx;
    logic [3:0]  mid;
    logic [3:0]  prev_en;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(4);
    // R1 / R9 reset state
    chk("R1", "ch_on after reset", 16'(ch_on), 16'h0);
    chk("R1", "so after reset", 16'(so), 16'h0);
    chk("R9", "so_oe idle", 16'(so_oe), 16'h0);

    // Table of frames: R2, R4, R5, R6, R10
    prev_en = 4'h0;
    for (int v = 0; v < NV; v++) begin
      fault = VECS[v].flt;
      par   = VECS[v].pin;
      run_frame(int'(VECS[v].nbits), VECS[v].tx, rx, mid);
      chk(VECS[v].nbits == 5'd16 ? "R6" : "R2", "so stream", rx, VECS[v].exp_so);
      chk("R10", "ch_on during frame", 16'(mid), 16'(prev_en | VECS[v].pin));
      chk("R4", "ch_on after frame (R5 OR)", 16'(ch_on), 16'(VECS[v].exp_on));
      prev_en = VECS[v].tx[3:0];
    end

    // R7: frame with no clock edges loads fault flags into enables
    par = 4'h0;
    fault = 4'hB;
    csb = 1'b0;
    wait_clk(8);
    chk("R9", "so_oe active", 16'(so_oe), 16'h1);
    csb = 1'b1;
    wait_clk(6);
    chk("R7", "ch_on after empty frame", 16'(ch_on), 16'hB);

    // R8: activity while deselected has no effect
    for (int k = 0; k < 6; k++) begin
      si = k[0];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    chk("R8", "ch_on after idle clocks", 16'(ch_on), 16'hB);
    chk("R9", "so idle", 16'(so), 16'h0);
    fault = 4'h2;
    run_frame(8, 16'h0000, rx, mid);
    chk("R8", "so stream after idle clocks", rx, 16'h0002);
    chk("R4", "ch_on cleared", 16'(ch_on), 16'h0);

    // R3: SO holds across rising edge, moves after falling edge
    fault = 4'hF;
    si = 1'b1;
    csb = 1'b0;
    wait_clk(5);
    for (int k = 0; k < 3; k++) begin
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    sclk = 1'b1;
    wait_clk(4);
    chk("R3", "so after 4th rise", 16'(so), 16'h0);
    sclk = 1'b0;
    wait_clk(4);
    chk("R3", "so after 4th fall", 16'(so), 16'h1);
    for (int k = 0; k < 4; k++) begin
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(5);
    csb = 1'b1;
    wait_clk(6);
    chk("R3", "ch_on from ones", 16'(ch_on), 16'hF);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule